// File: doc/BRIEF.md
# Bitfield Move and Extract Unit

This block is the bitfield datapath of an integer execution pipe. One rotator and one wrap-around mask generator serve three field operations: insert a field into an existing destination value, extract a field with zero extension, and extract a field with sign extension. A fourth operation joins two operands and takes a word-wide window out of the joined value at a given bit offset (a funnel shift). All four work on 64-bit operands or, in narrow mode, on the low 32 bits.

The field operations take two 6-bit immediates. The first, the rotate amount, is how far right the source is rotated. The second, the top index, marks the highest source bit of the field. When the rotate amount is at most the top index, the field lands at bit 0. When it is greater, the field wraps and lands higher in the word. For the signed variant, the fill bit is taken from the source bit at the top index, not from the most significant bit of the word.

Decoding and register access belong to the pipe around the block. Inputs are captured at each clock edge, and the result appears on the outputs one cycle later.

Top module: `bfx_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `result` and `illegal` become zero after that edge.
- R2: `result` and `illegal` reflect the inputs sampled at the previous rising edge and hold between edges.
- R3: Operation select encodings are 0 = insert, 1 = zero-extend, 2 = sign-extend, 3 = extract. For codes 0 to 2 the mask is formed as follows. When `imm_rot` <= `imm_top`, the mask holds `imm_top`-`imm_rot`+1 ones starting at bit 0. With zero-extend, `result` equals `src_a` rotated right by `imm_rot` within the width, ANDed with that mask.
- R4: When `imm_rot` > `imm_top`, the mask is `imm_top`+1 low ones rotated right by `imm_rot` within the operand width.
- R5: Insert outputs the rotated, masked `src_a`. Every bit outside the mask is taken from `dst_in`.
- R6: Sign-extend adds the zero-extend result to a fill. When bit `imm_top` of `src_a` is one, every bit above the field span and inside the width is one. The span top is `imm_top`-`imm_rot`, or that value plus the width if `imm_rot` > `imm_top`.
- R7: Extract with a zero shift returns `src_b`. Any other shift returns `src_a` shifted left by (width - shift), ORed with `src_b` shifted right by the shift, all within the width.
- R8: With `narrow` high, all operations use the low 32 bits of the operands, and `result[63:32]` is zero.
- R9: With `narrow` high, `illegal` is one and `result` is zero in two cases: extract with `imm_rot` >= 32, or a field operation with either immediate >= 32. With `narrow` low, `illegal` is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_sel | input | 2 | 0 insert, 1 zero-extend, 2 sign-extend, 3 extract |
| narrow | input | 1 | 1 selects 32-bit operation |
| src_a | input | 64 | Field source; high half of the extract pair |
| src_b | input | 64 | Low half of the extract pair |
| dst_in | input | 64 | Current destination value for insert |
| imm_rot | input | 6 | Rotate amount, also the extract shift |
| imm_top | input | 6 | Top source bit index of the field |
| result | output | 64 | Registered result |
| illegal | output | 1 | Registered flag: narrow-mode immediate out of range |

## Verification
Directed vectors cover the boundaries of the mask logic. A rotate equal to the top index selects a single bit, which isolates the non-wrapping branch. A zero rotate with the top index at the highest bit gives a full-width mask, which checks whether insert and zero-extend pass the whole source. Larger rotates with small top indices take the wrapped branch and show whether the mask rotation and the widened span are right. Sign extension is run with both values of the chosen source bit, and extract with shifts of 0, 1 and the maximum, to expose off-by-one errors in the fill and in the funnel. Random operands and immediates in both widths then separate narrow-mode masking and the range flag from the wide path.

// File: rtl/bfx_pkg.sv
// Shared definitions for the bitfield unit.
// Assumes: the op encoding below is fixed by the decoder feeding the unit.
package bfx_pkg;
    typedef enum logic [1:0] {
        OP_INSERT  = 2'd0,
        OP_ZEXT    = 2'd1,
        OP_SEXT    = 2'd2,
        OP_EXTRACT = 2'd3
    } bfx_op_e;
endpackage

// File: rtl/bfx_rotator.sv
// Right-rotates a word within the selected width (full or half).
// Assumes: in narrow mode the amount is below XLEN/2; its top bit is ignored there.
module bfx_rotator #(
    parameter int XLEN  = 64,
    parameter int IMM_W = $clog2(XLEN)
) (
    input  logic             narrow,
    input  logic [XLEN-1:0]  data,
    input  logic [IMM_W-1:0] amt,
    output logic [XLEN-1:0]  q
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] wide_v;
    logic [HALF-1:0] half_v;

    // Rotate by shifting a doubled copy of the word in each width.
    always_comb begin
        wide_v = XLEN'({data, data} >> amt);
        half_v = HALF'({data[HALF-1:0], data[HALF-1:0]} >> amt[IMM_W-2:0]);
        q      = narrow ? {{HALF{1'b0}}, half_v} : wide_v;
    end
endmodule

// File: rtl/bfx_mask_gen.sv
// Builds the field mask (possibly wrapped) and the sign-fill mask above the span.
// Assumes: immediates are in range for the width; out-of-range results are
// discarded by the top level.
module bfx_mask_gen #(
    parameter int XLEN  = 64,
    parameter int IMM_W = $clog2(XLEN)
) (
    input  logic             narrow,
    input  logic [IMM_W-1:0] rot,
    input  logic [IMM_W-1:0] top,
    output logic [XLEN-1:0]  wmask,
    output logic [XLEN-1:0]  tmask
);
    localparam int HALF  = XLEN / 2;
    localparam int CNT_W = IMM_W + 2;

    // Low n bits set; saturates at the full word.
    function automatic logic [XLEN-1:0] ones(input logic [CNT_W-1:0] n);
        logic [XLEN-1:0] unit_v;
        unit_v = {{(XLEN-1){1'b0}}, 1'b1};
        if (int'(n) >= XLEN) ones = '1;
        else                 ones = (unit_v << n) - unit_v;
    endfunction

    logic             no_wrap;
    logic [CNT_W-1:0] width_c;
    logic [CNT_W-1:0] run_len;
    logic [CNT_W-1:0] span_top;
    logic [IMM_W-1:0] run_rot;
    logic [XLEN-1:0]  run_v;
    logic [XLEN-1:0]  width_mask;

    // Choose run length, its rotation and the span top from the immediate order.
    always_comb begin
        no_wrap    = (rot <= top);
        width_c    = narrow ? CNT_W'(HALF) : CNT_W'(XLEN);
        width_mask = narrow ? {{HALF{1'b0}}, {HALF{1'b1}}} : '1;
        if (no_wrap) begin
            run_len  = CNT_W'(top) - CNT_W'(rot) + CNT_W'(1);
            run_rot  = '0;
            span_top = CNT_W'(top) - CNT_W'(rot);
        end else begin
            run_len  = CNT_W'(top) + CNT_W'(1);
            run_rot  = rot;
            span_top = CNT_W'(top) + width_c - CNT_W'(rot);
        end
        run_v = ones(run_len);
        tmask = ~ones(span_top + CNT_W'(1)) & width_mask;
    end

    bfx_rotator #(.XLEN(XLEN), .IMM_W(IMM_W)) run_rot_i (
        .narrow (narrow),
        .data   (run_v),
        .amt    (run_rot),
        .q      (wmask)
    );
endmodule

// File: rtl/bfx_funnel.sv
// Takes a width-sized window out of the pair {hi, lo} starting at bit amt.
// Assumes: in narrow mode amt is below XLEN/2.
module bfx_funnel #(
    parameter int XLEN  = 64,
    parameter int IMM_W = $clog2(XLEN)
) (
    input  logic             narrow,
    input  logic [XLEN-1:0]  hi,
    input  logic [XLEN-1:0]  lo,
    input  logic [IMM_W-1:0] amt,
    output logic [XLEN-1:0]  q
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] wide_v;
    logic [HALF-1:0] half_v;

    // Shift the concatenated pair right; a zero amount leaves lo in place.
    always_comb begin
        wide_v = XLEN'({hi, lo} >> amt);
        half_v = HALF'({hi[HALF-1:0], lo[HALF-1:0]} >> amt[IMM_W-2:0]);
        q      = narrow ? {{HALF{1'b0}}, half_v} : wide_v;
    end
endmodule

// File: rtl/bfx_unit.sv
// Bitfield insert / zero-extract / sign-extract and pair extract, one cycle latency.
// Assumes: inputs are stable around the rising edge; synchronous active-low reset.
module bfx_unit #(
    parameter int XLEN  = 64,
    parameter int IMM_W = $clog2(XLEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       op_sel,
    input  logic             narrow,
    input  logic [XLEN-1:0]  src_a,
    input  logic [XLEN-1:0]  src_b,
    input  logic [XLEN-1:0]  dst_in,
    input  logic [IMM_W-1:0] imm_rot,
    input  logic [IMM_W-1:0] imm_top,
    output logic [XLEN-1:0]  result,
    output logic             illegal
);
    import bfx_pkg::*;

    localparam int HALF = XLEN / 2;

    bfx_op_e         op;
    logic [XLEN-1:0] rot_src;
    logic [XLEN-1:0] wmask;
    logic [XLEN-1:0] tmask;
    logic [XLEN-1:0] funnel_q;
    logic [XLEN-1:0] field;
    logic [XLEN-1:0] res_d;
    logic            ill_d;
    logic            sign_bit;

    assign op = bfx_op_e'(op_sel);

    bfx_rotator #(.XLEN(XLEN), .IMM_W(IMM_W)) src_rot_i (
        .narrow (narrow),
        .data   (src_a),
        .amt    (imm_rot),
        .q      (rot_src)
    );

    bfx_mask_gen #(.XLEN(XLEN), .IMM_W(IMM_W)) mask_i (
        .narrow (narrow),
        .rot    (imm_rot),
        .top    (imm_top),
        .wmask  (wmask),
        .tmask  (tmask)
    );

    bfx_funnel #(.XLEN(XLEN), .IMM_W(IMM_W)) funnel_i (
        .narrow (narrow),
        .hi     (src_a),
        .lo     (src_b),
        .amt    (imm_rot),
        .q      (funnel_q)
    );

    // Select the operation result, clear the upper half in narrow mode, flag range errors.
    always_comb begin
        field    = rot_src & wmask;
        sign_bit = src_a[imm_top];
        unique case (op)
            OP_INSERT:  res_d = field | (dst_in & ~wmask);
            OP_ZEXT:    res_d = field;
            OP_SEXT:    res_d = field | (sign_bit ? tmask : '0);
            OP_EXTRACT: res_d = funnel_q;
            default:    res_d = '0;
        endcase
        if (narrow) res_d[XLEN-1:HALF] = '0;
        if (op == OP_EXTRACT) ill_d = narrow && imm_rot[IMM_W-1];
        else                  ill_d = narrow && (imm_rot[IMM_W-1] || imm_top[IMM_W-1]);
        if (ill_d) res_d = '0;
    end

    // Output register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result  <= '0;
            illegal <= 1'b0;
        end else begin
            result  <= res_d;
            illegal <= ill_d;
        end
    end
endmodule

// File: rtl/bfx_unit_chk.sv
// Checker for bfx_unit: relates outputs to inputs of the previous cycle.
module bfx_unit_chk #(
    parameter int XLEN  = 64,
    parameter int IMM_W = $clog2(XLEN)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       op_sel,
    input logic             narrow,
    input logic [XLEN-1:0]  src_a,
    input logic [XLEN-1:0]  src_b,
    input logic [IMM_W-1:0] imm_rot,
    input logic [IMM_W-1:0] imm_top,
    input logic [XLEN-1:0]  result,
    input logic             illegal
);
    localparam int HALF = XLEN / 2;

    a_r8_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        narrow |=> (result[XLEN-1:HALF] == '0));

    a_r9_illegal_zeroes_result: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (result == '0));

    a_r9_wide_never_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        !narrow |=> !illegal);

    a_r7_zero_shift_passes_low: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'd3 && !narrow && imm_rot == '0) |=> (result == $past(src_b)));

    a_r3_full_mask_passes_src: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'd1 && !narrow && imm_rot == '0 && imm_top == '1) |=> (result == $past(src_a)));
endmodule

bind bfx_unit bfx_unit_chk #(.XLEN(XLEN), .IMM_W(IMM_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_sel  (op_sel),
    .narrow  (narrow),
    .src_a   (src_a),
    .src_b   (src_b),
    .imm_rot (imm_rot),
    .imm_top (imm_top),
    .result  (result),
    .illegal (illegal)
);

// File: tb/bfx_unit_tb_top.sv
`timescale 1ns/1ps
module bfx_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op_sel = '0;
    logic        narrow = 1'b0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic [63:0] dst_in = '0;
    logic [5:0]  imm_rot = '0;
    logic [5:0]  imm_top = '0;
    logic [63:0] result;
    logic        illegal;

    int vectors = 0;
    int miscompares = 0;

    always #2 clk = ~clk;

    bfx_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .narrow(narrow),
        .src_a(src_a), .src_b(src_b), .dst_in(dst_in),
        .imm_rot(imm_rot), .imm_top(imm_top),
        .result(result), .illegal(illegal)
    );

    // Behavioural model, bit by bit: returns {illegal, result}.
    function automatic logic [64:0] model(input int op, input bit nar, input logic [63:0] a,
                                          input logic [63:0] b, input logic [63:0] d,
                                          input int r, input int t);
        int w;
        int span;
        bit ill;
        logic [63:0] rs, m, res;
        w = nar ? 32 : 64;
        ill = nar && ((op == 3) ? (r >= 32) : (r >= 32 || t >= 32));
        res = '0; rs = '0; m = '0;
        if (ill) return {1'b1, 64'd0};
        if (op == 3) begin
            for (int i = 0; i < w; i++)
                res[i] = (i + r < w) ? b[i + r] : a[i + r - w];
        end else begin
            for (int i = 0; i < w; i++) rs[i] = a[(i + r) % w];
            if (r <= t) begin
                for (int i = 0; i <= t - r; i++) m[i] = 1'b1;
                span = t - r;
            end else begin
                for (int j = 0; j <= t; j++) m[(j + w - r) % w] = 1'b1;
                span = t + w - r;
            end
            for (int i = 0; i < w; i++) begin
                res[i] = rs[i] & m[i];
                if (op == 0 && !m[i]) res[i] = d[i];
                if (op == 2 && a[t] && i > span) res[i] = 1'b1;
            end
        end
        return {1'b0, res};
    endfunction

    task automatic compare(input string tag, input logic [64:0] exp);
        vectors++;
        if ({illegal, result} !== exp) begin
            miscompares++;
            $display("FAIL %s: actual ill=%0b res=%h expected ill=%0b res=%h",
                     tag, illegal, result, exp[64], exp[63:0]);
        end
    endtask

    // Drive at the falling edge, let one rising edge register it, sample 1 ns later.
    task automatic apply(input string tag, input int op, input bit nar, input logic [63:0] a,
                         input logic [63:0] b, input logic [63:0] d, input int r, input int t);
        @(negedge clk);
        op_sel = 2'(op); narrow = nar; src_a = a; src_b = b; dst_in = d;
        imm_rot = 6'(r); imm_top = 6'(t);
        @(posedge clk);
        #1;
        compare(tag, model(op, nar, a, b, d, r, t));
    endtask

    initial begin
        logic [64:0] held;
        // R1: reset clears the outputs even with active inputs
        @(negedge clk);
        op_sel = 2'd1; src_a = '1; imm_top = 6'd63;
        repeat (2) @(posedge clk);
        #1;
        compare("R1", 65'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: non-wrapping masks, including rotate equal to top and full width
        apply("R3", 1, 0, 64'h0123_4567_89AB_CDEF, 0, 0, 0, 63);
        apply("R3", 1, 0, 64'h0000_0000_0000_0020, 0, 0, 5, 5);
        apply("R3", 1, 0, 64'hFEDC_BA98_7654_3210, 0, 0, 12, 27);
        // R4: wrapped masks
        apply("R4", 1, 0, 64'hFEDC_BA98_7654_3210, 0, 0, 60, 7);
        apply("R4", 1, 0, 64'hA5A5_5A5A_F0F0_0F0F, 0, 0, 1, 0);
        // R5: insert keeps destination outside the mask
        apply("R5", 0, 0, 64'h1111_2222_3333_4444, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 63);
        apply("R5", 0, 0, 64'h0000_0000_0000_00AB, 0, 64'hDEAD_BEEF_CAFE_F00D, 56, 7);
        apply("R5", 0, 0, 64'h0000_0000_0000_FF00, 0, 64'h0, 8, 15);
        // R6: sign fill from the chosen bit, set and clear
        apply("R6", 2, 0, 64'h0000_0000_0000_8000, 0, 0, 8, 15);
        apply("R6", 2, 0, 64'h0000_0000_0000_7F00, 0, 0, 8, 15);
        apply("R6", 2, 0, 64'h0000_0000_0000_0080, 0, 0, 57, 7);
        // R7: extract shifts 0, 1 and maximum
        apply("R7", 3, 0, 64'hAAAA_BBBB_CCCC_DDDD, 64'h1234_5678_9ABC_DEF0, 0, 0, 0);
        apply("R7", 3, 0, 64'h0000_0000_0000_0001, 64'h8000_0000_0000_0000, 0, 1, 0);
        apply("R7", 3, 0, 64'hFFFF_0000_FFFF_0001, 64'h8000_0000_0000_0000, 0, 63, 0);
        // R8: narrow mode ignores upper operand halves
        apply("R8", 1, 1, 64'hFFFF_FFFF_8000_0001, 0, 0, 31, 31);
        apply("R8", 3, 1, 64'hFFFF_FFFF_0000_00FF, 64'hFFFF_FFFF_1234_5678, 0, 8, 0);
        apply("R8", 0, 1, 64'h0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 4, 11);
        apply("R8", 2, 1, 64'hFFFF_FFFF_0000_0800, 0, 0, 28, 11);
        // R9: narrow range flag; wide never flagged
        apply("R9", 1, 1, 64'h1, 0, 0, 32, 3);
        apply("R9", 2, 1, 64'h1, 0, 0, 3, 40);
        apply("R9", 3, 1, 64'h1, 64'h2, 0, 40, 0);
        apply("R9", 3, 1, 64'h1, 64'h2, 0, 5, 63);
        apply("R9", 1, 0, 64'h8000_0000_0000_0000, 0, 0, 63, 63);

        // R2: output holds until the next edge after inputs change
        apply("R2", 1, 0, 64'h0F0F_0F0F_0F0F_0F0F, 0, 0, 4, 19);
        held = {illegal, result};
        @(negedge clk);
        src_a = '1; op_sel = 2'd3; imm_rot = 6'd9;
        #1;
        compare("R2", held);

        // R3..R9: random sweep over every op code and both widths
        for (int k = 0; k < 3000; k++) begin
            int op = int'($urandom_range(0, 3));
            bit nar = bit'($urandom_range(0, 1));
            int r = nar ? int'($urandom_range(0, 35)) : int'($urandom_range(0, 63));
            int t = nar ? int'($urandom_range(0, 35)) : int'($urandom_range(0, 63));
            apply(op == 3 ? "R7" : (op == 0 ? "R5" : (op == 2 ? "R6" : "R4")), op, nar,
                  {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom}, r, t);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL R2: actual run still active expected finished before watchdog");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule